// File: doc/BRIEF.md
# DRAM ECC Error Logging Register Bank

This block is the error-capture and reporting register bank of a DRAM controller. Each cycle the memory datapath can present one ECC result: a correctable flag, an uncorrectable flag, the 33-bit physical address, the channel number and the 8-bit syndrome. Three other error events can also arrive: a refresh timeout, a locked access that targets non-DRAM memory, and a thermal sensor trip. The block keeps sticky status flags for all five sources. For the ECC errors it also holds one captured record: the address at a 128-byte grain, the channel and the syndrome.

Software reads and writes the bank through a word-indexed register port. Per-byte write enables allow byte, halfword and word accesses. A status flag is cleared by writing a one to it. A per-source enable field decides which set flags drive the system-error output. An uncorrectable error takes over a captured record that belongs to a correctable error. A correctable error never replaces the record of an uncorrectable error. Among errors of the same kind, the first one is kept until its flag is cleared.

Register layout by word index:
- Word 0: status in bits 15:0 and the enable field in bits 31:16.
- Word 1: the error pointer.
- Word 2: the syndrome and the address extension bit.
- Word 3: reads as zero.

Top module: `dram_ecc_errlog`

## Requirements
- R1: After reset, every register word reads zero and `serr_o` is low.
- R2: Status (word 0, bits 15:0) has these flags: correctable ECC at bit 0, uncorrectable ECC at bit 1, refresh timeout at bit 8, non-DRAM lock at bit 9, thermal at bit 11. Each is set one cycle after its event input is high. All other status bits read zero (valid mask 0x0B03).
- R3: A write to word 0 with a one in a status bit clears that flag. A zero leaves the flag unchanged. Lane 0 (`reg_be[0]`) covers bits 7:0 and lane 1 covers bits 15:8. A bit in a lane that is not enabled is not cleared.
- R4: With no ECC flag set, an ECC error captures its record. Word 1 holds address bits 31:7 in bits 31:7, zeros in bits 6:1 and the channel in bit 0. Word 2 holds the syndrome in bits 7:0 and address bit 32 in bit 8. All other bits of word 2 read zero.
- R5: An uncorrectable error that arrives while only the correctable flag is set overwrites the captured record. The correctable flag stays set.
- R6: While the uncorrectable flag is set, a new error of either kind sets its flag but leaves the captured record unchanged.
- R7: While the correctable flag is set, a further correctable error leaves the record unchanged (the first one wins).
- R8: If correctable and uncorrectable errors arrive in the same cycle, the uncorrectable error's record is captured and both flags are set.
- R9: A clear and a new event on the same status bit in the same cycle leave the bit set.
- R10: The enable field (word 0, bits 31:16) stores only bits 0, 1, 8, 9 and 11, in the same positions as the status flags. All other bits read zero. Lane 2 writes bits 7:0 of the field and lane 3 writes bits 15:8.
- R11: `serr_o` is high exactly when some status flag and its enable bit are both set.
- R12: Writes to words 1, 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ce | input | 1 | Correctable ECC error this cycle |
| ev_ue | input | 1 | Uncorrectable ECC error this cycle |
| ev_addr | input | 33 | Physical address of the ECC error |
| ev_chan | input | 1 | Channel of the ECC error |
| ev_syn | input | 8 | ECC syndrome of the error |
| ev_refto | input | 1 | Refresh timeout event |
| ev_lock | input | 1 | Locked access to non-DRAM memory event |
| ev_therm | input | 1 | Thermal sensor event |
| reg_word | input | 2 | Register word index |
| reg_we | input | 1 | Write strobe |
| reg_be | input | 4 | Byte lane enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed word (combinational) |
| serr_o | output | 1 | System-error output |

## Verification
Directed sequences set up each capture ordering in turn:
- a lone correctable error, then a correctable error followed by an uncorrectable one (R5);
- an uncorrectable error followed by a correctable one and by a second uncorrectable one (R6);
- two correctable errors in a row (R7);
- simultaneous correctable and uncorrectable errors (R8).

Together these separate "uncorrectable overrides" from "last writer wins" and from "first writer wins". Further directed cases pair a clear with an event on the same bit, and use partial lane writes to show that clears and enable updates stay within their byte. Seeded random traffic mixes sparse events with random writes to all four words, and each cycle its results are compared with a bench model of the whole register bank.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
    localparam int ADDR_W    = 33;          // physical address width
    localparam int SYN_W     = 8;           // ECC syndrome width
    localparam int GRAIN_LSB = 7;           // 128-byte capture grain
    localparam int WORD_W    = 32;          // register word width
    localparam int LANES     = WORD_W / 8;
    localparam int STS_W     = 16;
    localparam int WIDX_W    = 2;
    localparam int HI_W      = ADDR_W - GRAIN_LSB;      // captured address bits
    localparam int PTR_HI_W  = WORD_W - GRAIN_LSB;      // bits held in the pointer word
    localparam int EXT_W     = HI_W - PTR_HI_W;         // bits held in the extension

    // Status / enable bit positions (shared by both fields)
    localparam int BIT_CE    = 0;
    localparam int BIT_UE    = 1;
    localparam int BIT_REFTO = 8;
    localparam int BIT_LOCK  = 9;
    localparam int BIT_THERM = 11;
    localparam logic [STS_W-1:0] STS_MASK = 16'h0B03;

    // Word indices
    localparam logic [WIDX_W-1:0] W_CTL = 2'd0;
    localparam logic [WIDX_W-1:0] W_PTR = 2'd1;
    localparam logic [WIDX_W-1:0] W_SYN = 2'd2;

    typedef struct packed {
        logic [STS_W-1:0] sts;
        logic [HI_W-1:0]  ahi;
        logic             chan;
        logic [SYN_W-1:0] syn;
    } log_state_t;

    typedef struct packed {
        logic [STS_W-1:0] cmd;
    } port_state_t;
endpackage

// File: rtl/errlog_capture.sv
module errlog_capture
    import errlog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ce,
    input  logic              ev_ue,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              ev_chan,
    input  logic [SYN_W-1:0]  ev_syn,
    input  logic              ev_refto,
    input  logic              ev_lock,
    input  logic              ev_therm,
    input  logic [STS_W-1:0]  clr_mask,
    output logic [STS_W-1:0]  sts_q,
    output logic [HI_W-1:0]   ahi_q,
    output logic              chan_q,
    output logic [SYN_W-1:0]  syn_q
);
    log_state_t       st_d, st_q;
    logic [STS_W-1:0] set_vec;
    logic             take_ue, take_ce;
    logic [GRAIN_LSB-1:0] unused_low;

    assign unused_low = ev_addr[GRAIN_LSB-1:0];

    always_comb begin
        set_vec            = '0;
        set_vec[BIT_CE]    = ev_ce;
        set_vec[BIT_UE]    = ev_ue;
        set_vec[BIT_REFTO] = ev_refto;
        set_vec[BIT_LOCK]  = ev_lock;
        set_vec[BIT_THERM] = ev_therm;

        // Uncorrectable takes the record unless one is already held;
        // correctable takes it only when no ECC record is held at all.
        take_ue = ev_ue & ~st_q.sts[BIT_UE];
        take_ce = ev_ce & ~ev_ue & ~st_q.sts[BIT_UE] & ~st_q.sts[BIT_CE];

        st_d     = st_q;
        st_d.sts = ((st_q.sts & ~clr_mask) | set_vec) & STS_MASK;
        if (take_ue || take_ce) begin
            st_d.ahi  = ev_addr[ADDR_W-1:GRAIN_LSB];
            st_d.chan = ev_chan;
            st_d.syn  = ev_syn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_q  = st_q.sts;
    assign ahi_q  = st_q.ahi;
    assign chan_q = st_q.chan;
    assign syn_q  = st_q.syn;
endmodule

// File: rtl/errlog_regport.sv
module errlog_regport
    import errlog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDX_W-1:0] reg_word,
    input  logic              reg_we,
    input  logic [LANES-1:0]  reg_be,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [STS_W-1:0]  sts,
    input  logic [HI_W-1:0]   ahi,
    input  logic              chan,
    input  logic [SYN_W-1:0]  syn,
    output logic [STS_W-1:0]  clr_mask,
    output logic [STS_W-1:0]  cmd_q,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              serr_o
);
    port_state_t       ps_d, ps_q;
    logic [LANES-1:0]  lane_wr;
    logic [WORD_W-1:0] lane_bits;

    // Per-lane write strobes and bit masks, only toward the control word
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_wr[i] = reg_we & reg_be[i] & (reg_word == W_CTL);
        assign lane_bits[8*i +: 8] = {8{lane_wr[i]}};
    end

    always_comb begin
        clr_mask = reg_wdata[STS_W-1:0] & lane_bits[STS_W-1:0] & STS_MASK;

        ps_d     = ps_q;
        ps_d.cmd = ((ps_q.cmd & ~lane_bits[WORD_W-1:STS_W])
                   | (reg_wdata[WORD_W-1:STS_W] & lane_bits[WORD_W-1:STS_W]))
                   & STS_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_word)
            W_CTL: reg_rdata = {ps_q.cmd, sts};
            W_PTR: reg_rdata = {ahi[PTR_HI_W-1:0], {(GRAIN_LSB-1){1'b0}}, chan};
            W_SYN: reg_rdata[SYN_W+EXT_W-1:0] = {ahi[HI_W-1:PTR_HI_W], syn};
            default: reg_rdata = '0;
        endcase
    end

    assign cmd_q  = ps_q.cmd;
    assign serr_o = |(sts & ps_q.cmd);
endmodule

// File: rtl/dram_ecc_errlog.sv
module dram_ecc_errlog
    import errlog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ce,
    input  logic              ev_ue,
    input  logic [32:0]       ev_addr,
    input  logic              ev_chan,
    input  logic [7:0]        ev_syn,
    input  logic              ev_refto,
    input  logic              ev_lock,
    input  logic              ev_therm,
    input  logic [1:0]        reg_word,
    input  logic              reg_we,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              serr_o
);
    logic [STS_W-1:0] clr_w, sts_w, cmd_w;
    logic [HI_W-1:0]  ahi_w;
    logic             chan_w;
    logic [SYN_W-1:0] syn_w;

    errlog_capture u_cap (
        .clk(clk), .rst_n(rst_n),
        .ev_ce(ev_ce), .ev_ue(ev_ue), .ev_addr(ev_addr), .ev_chan(ev_chan),
        .ev_syn(ev_syn), .ev_refto(ev_refto), .ev_lock(ev_lock),
        .ev_therm(ev_therm), .clr_mask(clr_w),
        .sts_q(sts_w), .ahi_q(ahi_w), .chan_q(chan_w), .syn_q(syn_w)
    );

    errlog_regport u_port (
        .clk(clk), .rst_n(rst_n),
        .reg_word(reg_word), .reg_we(reg_we), .reg_be(reg_be),
        .reg_wdata(reg_wdata),
        .sts(sts_w), .ahi(ahi_w), .chan(chan_w), .syn(syn_w),
        .clr_mask(clr_w), .cmd_q(cmd_w), .reg_rdata(reg_rdata),
        .serr_o(serr_o)
    );
endmodule

// File: rtl/errlog_checker.sv
module errlog_checker
    import errlog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ev_ce,
    input logic             ev_ue,
    input logic             ev_chan,
    input logic [SYN_W-1:0] ev_syn,
    input logic [STS_W-1:0] sts,
    input logic [STS_W-1:0] cmd,
    input logic [HI_W-1:0]  ahi,
    input logic             chan,
    input logic [SYN_W-1:0] syn,
    input logic             serr
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (sts == '0 && cmd == '0));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sts & ~STS_MASK) == '0);

    assert_ce_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ce |=> sts[BIT_CE]);

    assert_ue_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ue |=> sts[BIT_UE]);

    assert_ue_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ue && !sts[BIT_UE]) |=> (chan == $past(ev_chan) && syn == $past(ev_syn)));

    assert_ue_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sts[BIT_UE] |=> ($stable(ahi) && $stable(chan) && $stable(syn)));

    assert_cmd_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd & ~STS_MASK) == '0);

    assert_serr_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & cmd) != '0) |-> serr);
endmodule

bind dram_ecc_errlog errlog_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ev_ce(ev_ce), .ev_ue(ev_ue),
    .ev_chan(ev_chan), .ev_syn(ev_syn), .sts(sts_w), .cmd(cmd_w),
    .ahi(ahi_w), .chan(chan_w), .syn(syn_w), .serr(serr_o)
);

// File: tb/dram_ecc_errlog_tb.sv
module dram_ecc_errlog_tb_top;
    logic        clk = 0, rst_n = 0;
    logic        ev_ce = 0, ev_ue = 0, ev_chan = 0, ev_refto = 0, ev_lock = 0, ev_therm = 0;
    logic [32:0] ev_addr = '0;
    logic [7:0]  ev_syn = '0;
    logic [1:0]  reg_word = '0;
    logic        reg_we = 0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        serr_o;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // bench model
    logic [15:0] m_sts = '0, m_cmd = '0;
    logic [25:0] m_ahi = '0;
    logic        m_ch = 0;
    logic [7:0]  m_syn = '0;

    always #4 clk = ~clk;   // 125 MHz

    dram_ecc_errlog dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [1:0] w);
        case (w)
            2'd0: return {m_cmd, m_sts};
            2'd1: return {m_ahi[24:0], 6'b0, m_ch};
            2'd2: return {23'b0, m_ahi[25], m_syn};
            default: return 32'h0;
        endcase
    endfunction

    task automatic step(input bit ce, input bit ue, input logic [32:0] a, input bit ch,
                        input logic [7:0] sy, input bit rt, input bit lk, input bit th,
                        input bit we, input logic [1:0] wi, input logic [3:0] be,
                        input logic [31:0] wd);
        logic [15:0] clr, setv;
        @(negedge clk);
        ev_ce = ce; ev_ue = ue; ev_addr = a; ev_chan = ch; ev_syn = sy;
        ev_refto = rt; ev_lock = lk; ev_therm = th;
        reg_we = we; reg_word = wi; reg_be = be; reg_wdata = wd;
        clr = '0;
        if (we && wi == 2'd0) begin
            if (be[0]) clr[7:0]  = wd[7:0];
            if (be[1]) clr[15:8] = wd[15:8];
            if (be[2]) m_cmd[7:0]  = wd[23:16] & 8'h03;
            if (be[3]) m_cmd[15:8] = wd[31:24] & 8'h0B;
        end
        clr &= 16'h0B03;
        if ((ue && !m_sts[1]) || (ce && !ue && m_sts[1:0] == 2'b00)) begin
            m_ahi = a[32:7]; m_ch = ch; m_syn = sy;
        end
        setv = '0;
        setv[0] = ce; setv[1] = ue; setv[8] = rt; setv[9] = lk; setv[11] = th;
        m_sts = (m_sts & ~clr) | setv;
        @(posedge clk);
        #1;
        ev_ce = 0; ev_ue = 0; ev_refto = 0; ev_lock = 0; ev_therm = 0; reg_we = 0;
    endtask

    task automatic idle();
        step(0, 0, '0, 0, '0, 0, 0, 0, 0, 2'd0, 4'h0, '0);
    endtask

    task automatic wr(input logic [1:0] wi, input logic [3:0] be, input logic [31:0] wd);
        step(0, 0, '0, 0, '0, 0, 0, 0, 1, wi, be, wd);
    endtask

    task automatic ecc(input bit ce, input bit ue, input logic [32:0] a, input bit ch,
                       input logic [7:0] sy);
        step(ce, ue, a, ch, sy, 0, 0, 0, 0, 2'd0, 4'h0, '0);
    endtask

    task automatic check_all(input string req);
        for (int w = 0; w < 4; w++) begin
            reg_word = w[1:0];
            #0.5;
            chk(req, reg_rdata, exp_word(w[1:0]));
        end
        chk({req, " serr"}, {31'b0, serr_o}, {31'b0, |(m_sts & m_cmd)});
    endtask

    initial begin
        #1_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check_all("R1");
        rst_n = 1;
        idle();
        check_all("R1 after release");

        // R2: flag positions
        step(0, 0, '0, 0, '0, 1, 1, 1, 0, 2'd0, 4'h0, '0);
        check_all("R2 other events");
        chk("R2 status", reg_rdata & 32'h0, 32'h0);
        reg_word = 0; #0.5;
        chk("R2 positions", reg_rdata, 32'h0000_0B00);
        // R3: lane 1 clear of bit 8 only, lane 0 write of bit 9 ignored (wrong lane)
        wr(2'd0, 4'b0010, 32'h0000_0100);
        check_all("R3 partial clear");
        wr(2'd0, 4'b0001, 32'h0000_FFFF);
        check_all("R3 disabled lane");
        wr(2'd0, 4'b0011, 32'h0000_0000);
        check_all("R3 zero write");
        wr(2'd0, 4'b0011, 32'h0000_FFFF);
        check_all("R3 full clear");

        // R4: first CE capture, bit 32 set
        ecc(1, 0, 33'h1_2345_67FF, 1, 8'hA5);
        check_all("R4 capture");
        reg_word = 1; #0.5;
        chk("R4 pointer", reg_rdata, 32'h2345_6781);
        reg_word = 2; #0.5;
        chk("R4 ext+syn", reg_rdata, 32'h0000_01A5);
        // R7: second CE ignored
        ecc(1, 0, 33'h0_0000_0080, 0, 8'h11);
        check_all("R7 first wins");
        // R5: UE overwrites CE record
        ecc(0, 1, 33'h0_ABCD_EF00, 0, 8'h3C);
        check_all("R5 override");
        reg_word = 0; #0.5;
        chk("R5 CE stays", reg_rdata & 32'h3, 32'h3);
        // R6: CE and UE while UE held
        ecc(1, 0, 33'h1_FFFF_FF80, 1, 8'hEE);
        check_all("R6 CE ignored");
        ecc(0, 1, 33'h1_0000_0000, 1, 8'h77);
        check_all("R6 UE ignored");
        wr(2'd0, 4'b0001, 32'h0000_0003);
        check_all("R3 clear ecc");

        // R8: simultaneous
        ecc(1, 1, 33'h0_1111_1180, 1, 8'h5A);
        check_all("R8 simultaneous");
        reg_word = 2; #0.5;
        chk("R8 syn", reg_rdata, 32'h0000_005A);
        // R9: clear and set same cycle
        step(1, 0, 33'h0_2222_2200, 0, 8'h01, 0, 0, 0, 1, 2'd0, 4'b0001, 32'h0000_0001);
        check_all("R9 set wins");
        reg_word = 0; #0.5;
        chk("R9 bit0", reg_rdata & 32'h1, 32'h1);

        // R10/R11: enable field and serr
        wr(2'd0, 4'b0100, 32'hFFFF_FFFF);
        check_all("R10 lane2");
        chk("R11 serr", {31'b0, serr_o}, 32'h1);
        wr(2'd0, 4'b1000, 32'hFFFF_FFFF);
        check_all("R10 lane3");
        reg_word = 0; #0.5;
        chk("R10 field", reg_rdata & 32'hFFFF_0000, 32'h0B03_0000);
        wr(2'd0, 4'b0011, 32'h0000_0B03);
        check_all("R11 serr drops");
        chk("R11 low", {31'b0, serr_o}, 32'h0);
        step(0, 0, '0, 0, '0, 0, 0, 1, 0, 2'd0, 4'h0, '0);
        check_all("R11 thermal");

        // R12: read-only words
        wr(2'd1, 4'hF, 32'hFFFF_FFFF);
        wr(2'd2, 4'hF, 32'hFFFF_FFFF);
        wr(2'd3, 4'hF, 32'hFFFF_FFFF);
        check_all("R12 ignored");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [32:0] a;
            a = {$urandom_range(1, 0), $urandom()};
            step(($urandom_range(7, 0) == 0), ($urandom_range(11, 0) == 0), a,
                 $urandom_range(1, 0), $urandom_range(255, 0),
                 ($urandom_range(15, 0) == 0), ($urandom_range(15, 0) == 0),
                 ($urandom_range(15, 0) == 0),
                 ($urandom_range(3, 0) == 0), $urandom_range(3, 0),
                 $urandom_range(15, 0), $urandom());
            check_all("R5 R6 R7 R9 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule